// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter that sits on a microprocessor bus. The host starts a conversion with active-low chip select and write strobes. It is told of completion through an active-low interrupt, and it collects the result with a chip-select plus read access. On the analog side the block presents a trial code to an external DAC and receives one comparator bit back. That bit is high when the sampled input is at or above the trial level.

A free-running divide-by-8 bit timer paces everything. A start can only launch on a timer tick, so a conversion begins 1 to 8 clocks after the strobe is released. Each of the eight bit decisions occupies one full tick interval of 8 clocks. A one-hot marker walks from the most significant bit to the least significant bit. After the last decision, one more clock moves the code into the result latch and raises the interrupt. The host reads the result on a bus modelled as a data value plus an output-enable. When the interrupt output is wired back to the write strobe with chip select held low, the block converts back to back.

The controller is a five-state machine:
- `ST_IDLE`: waits for a start.
- `ST_HOLD`: strobes held low; the search is kept in reset.
- `ST_ARMED`: strobes released; waits for a tick.
- `ST_CONV`: the search is running.
- `ST_DONE`: the one-clock latch-and-flag step.

Its transitions are:
- IDLE→HOLD on a start request.
- HOLD→CONV if the release coincides with a tick, otherwise HOLD→ARMED.
- ARMED→CONV on the next tick.
- CONV→DONE on the tick that decides bit 0.
- DONE→IDLE.
- Any state→HOLD whenever chip select and write are both low. This is the abort path.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While cs_n and wr_n are both low, trial_code reads 0x00 and intr_n reads high from the next clock on, and no conversion progresses.
- R2: The trial code first becomes 0x80 between 1 and 8 clocks after the start condition is released. Releasing at each of 8 consecutive clock phases yields all 8 latencies.
- R3: A conversion begins with trial_code = 0x80 (MSB first). Each trial code is held for exactly 8 clocks. At the end of each interval the tested bit is kept if cmp_above is 1 and cleared otherwise, and the next lower bit is set.
- R4: intr_n falls 65 clocks after the clock that first shows 0x80. The latched result equals the input code found by the search, so a full-scale input gives 0xFF and a comparator that is never high gives 0x00.
- R5: intr_n is high from start until completion and falls only on the clock that loads the result.
- R6: With cs_n and rd_n both low, data_oe is 1 and data_out shows the latched result in the same cycle. Otherwise data_oe is 0 and data_out is 0x00. A read clears the interrupt at the next clock, and the interrupt stays cleared after the read ends.
- R7: The result latch keeps the previous code during a new conversion, so a read mid-conversion returns the last complete code.
- R8: Pulling cs_n and wr_n low during a conversion aborts it: trial_code returns to 0x00 and intr_n stays high. A new start afterwards completes with the new input.
- R9: With intr_n fed back to wr_n and cs_n held low, conversions repeat back to back. Successive interrupt falls are 67 to 74 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Power-up reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write (start) strobe, active low |
| cmp_above | input | 1 | Comparator: input at or above trial level |
| trial_code | output | 8 | Code driven to the external DAC |
| data_out | output | 8 | Bus data value, 0 when not enabled |
| data_oe | output | 1 | Bus output enable (1 = driven, 0 = high impedance) |
| intr_n | output | 1 | Conversion-complete interrupt, active low |

## Verification
The bench releases the start strobe at every phase of the bit timer. It confirms that each latency from 1 to 8 appears, which a design that launched without waiting for a tick, or that waited an extra interval, would fail. It sweeps all 256 input codes in free-running mode, where an off-by-one in the bit interval or a wrong keep/clear rule would corrupt codes or shift the period outside 67 to 74 clocks. It also aborts a conversion midway, reads mid-conversion, and reads with a comparator stuck low. These checks expose a latch that updates early, an abort that leaves stale trial bits, and a read that fails to clear the interrupt.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_ARMED,
        ST_CONV,
        ST_DONE
    } sar_state_t;

endpackage

// File: rtl/sar_bit_timer.sv
module sar_bit_timer #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = (phase == LAST);

endmodule

// File: rtl/sar_search.sv
module sar_search #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         launch,
    input  logic         step,
    input  logic         cmp_above,
    output logic [W-1:0] code,
    output logic         last
);
    localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] marker;
    logic [W-1:0] code_nx;

    // tested bit takes the comparator verdict, the next lower bit becomes the new trial
    always_comb begin
        code_nx = (code & ~marker) | (cmp_above ? marker : '0) | (marker >> 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            code   <= '0;
            marker <= '0;
        end else if (launch) begin
            code   <= MSB_ONLY;
            marker <= MSB_ONLY;
        end else if (step) begin
            code   <= code_nx;
            marker <= marker >> 1;
        end
    end

    assign last = marker[0];

endmodule

// File: rtl/sar_out_port.sv
module sar_out_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] code_in,
    input  logic         rd_sel,
    output logic [W-1:0] data_out,
    output logic         data_oe
);
    logic [W-1:0] result_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (load) begin
            result_q <= code_in;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bus
        assign data_out[i] = result_q[i] & rd_sel;
    end

    assign data_oe = rd_sel;

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int CLKS_PER_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              cmp_above,
    output logic [DATA_W-1:0] trial_code,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              intr_n
);
    sar_state_t state;
    sar_state_t state_nx;

    logic hold_req;
    logic rd_sel;
    logic bit_tick;
    logic last_bit;
    logic sar_clear;
    logic sar_launch;
    logic sar_step;
    logic res_load;
    logic intr_flag;

    assign hold_req = !cs_n && !wr_n;
    assign rd_sel   = !cs_n && !rd_n;

    sar_bit_timer #(.DIV(CLKS_PER_BIT)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (bit_tick)
    );

    sar_search #(.W(DATA_W)) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sar_clear),
        .launch   (sar_launch),
        .step     (sar_step),
        .cmp_above(cmp_above),
        .code     (trial_code),
        .last     (last_bit)
    );

    sar_out_port #(.W(DATA_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (res_load),
        .code_in (trial_code),
        .rd_sel  (rd_sel),
        .data_out(data_out),
        .data_oe (data_oe)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (hold_req) state_nx = ST_HOLD;
            ST_HOLD:  if (!hold_req) state_nx = bit_tick ? ST_CONV : ST_ARMED;
            ST_ARMED: begin
                if (hold_req)      state_nx = ST_HOLD;
                else if (bit_tick) state_nx = ST_CONV;
            end
            ST_CONV: begin
                if (hold_req)                  state_nx = ST_HOLD;
                else if (bit_tick && last_bit) state_nx = ST_DONE;
            end
            ST_DONE:  state_nx = hold_req ? ST_HOLD : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // per-state outputs
    always_comb begin
        sar_clear  = hold_req;
        sar_launch = 1'b0;
        sar_step   = 1'b0;
        res_load   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_HOLD:  sar_launch = !hold_req && bit_tick;
            ST_ARMED: sar_launch = !hold_req && bit_tick;
            ST_CONV:  sar_step   = !hold_req && bit_tick;
            ST_DONE:  res_load   = !hold_req;
            default:  ;
        endcase
    end

    // interrupt flag: strobe hold clears, completion sets (wins over a read), read clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intr_flag <= 1'b0;
        end else if (hold_req) begin
            intr_flag <= 1'b0;
        end else if (res_load) begin
            intr_flag <= 1'b1;
        end else if (rd_sel) begin
            intr_flag <= 1'b0;
        end
    end

    assign intr_n = !intr_flag;

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk
    import sar_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n,
    input logic         rd_n,
    input logic         wr_n,
    input logic [W-1:0] trial_code,
    input logic [W-1:0] data_out,
    input logic         data_oe,
    input logic         intr_n,
    input sar_state_t   state,
    input logic         bit_tick
);
    localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

    assert_hold_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n) |=> (trial_code == '0 && intr_n));

    assert_msb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_CONV) |-> (trial_code == MSB_ONLY));

    assert_bit_interval_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && !bit_tick && !(!cs_n && !wr_n)) |=> $stable(trial_code));

    assert_intr_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr_n) |-> ($past(state) == ST_DONE));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && state != ST_DONE) |=> intr_n);

    assert_bus_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0));

    assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe) && $past(state) != ST_DONE) |-> $stable(data_out));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .trial_code(trial_code),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .intr_n    (intr_n),
    .state     (state),
    .bit_tick  (bit_tick)
);

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n;
    logic       rd_n;
    logic       wr_reg;
    logic       wr_n;
    logic       cmp_above;
    logic [7:0] trial_code;
    logic [7:0] data_out;
    logic       data_oe;
    logic       intr_n;

    logic [7:0] target;
    logic       never_above;
    logic       free_run;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    assign wr_n      = free_run ? (wr_reg & intr_n) : wr_reg;
    assign cmp_above = never_above ? 1'b0 : (target >= trial_code);

    sar_adc_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .cmp_above (cmp_above),
        .trial_code(trial_code),
        .data_out  (data_out),
        .data_oe   (data_oe),
        .intr_n    (intr_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_intr(output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (intr_n && cnt < 300);
    endtask

    task automatic read_result(input logic [7:0] exp, input string tag);
        rd_n = 1'b0;
        #1;
        check(data_oe == 1'b1, "R6 enable during read", int'(data_oe), 1);
        check(data_out == exp, tag, int'(data_out), int'(exp));
        @(negedge clk);
        check(intr_n == 1'b1, "R6 read clears interrupt", int'(intr_n), 1);
        rd_n = 1'b1;
        #1;
        check(!data_oe && data_out == 8'h00, "R6 bus released", int'(data_out), 0);
        @(negedge clk);
        check(intr_n == 1'b1, "R6 interrupt stays cleared", int'(intr_n), 1);
    endtask

    task automatic run_conv(input logic [7:0] tgt, input int hold_len, output int lat, output int dur);
        logic [7:0] second;
        target = tgt;
        second = (!never_above && tgt >= 8'h80) ? 8'hC0 : 8'h40;
        wr_reg = 1'b0;
        repeat (hold_len) @(negedge clk);
        check(trial_code == 8'h00 && intr_n, "R1 held in reset", int'(trial_code), 0);
        wr_reg = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (trial_code == 8'h00 && lat < 20);
        check(trial_code == 8'h80, "R3 first trial is MSB", int'(trial_code), 8'h80);
        dur = 0;
        do begin
            @(negedge clk);
            dur++;
            if (dur == 7) check(trial_code == 8'h80, "R3 trial held 8 clocks", int'(trial_code), 8'h80);
            if (dur == 8) check(trial_code == second, "R3 second trial", int'(trial_code), int'(second));
            if (dur < 65 && intr_n == 1'b0) check(1'b0, "R5 early interrupt", dur, 65);
        end while (intr_n && dur < 200);
        check(dur == 65, "R4 completion time", dur, 65);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int lat;
        int dur;
        int cnt;
        logic [7:0] mask;

        rst_n       = 1'b0;
        cs_n        = 1'b1;
        rd_n        = 1'b1;
        wr_reg      = 1'b1;
        target      = 8'h00;
        never_above = 1'b0;
        free_run    = 1'b0;
        repeat (3) @(negedge clk);
        check(intr_n == 1'b1, "R5 reset interrupt", int'(intr_n), 1);
        check(data_oe == 1'b0, "R6 reset bus", int'(data_oe), 0);
        check(trial_code == 8'h00, "R1 reset trial", int'(trial_code), 0);
        rst_n = 1'b1;
        cs_n  = 1'b0;
        @(negedge clk);

        // warm-up aligns the loop to the bit timer
        run_conv(8'h5A, 2, lat, dur);
        read_result(8'h5A, "R4 warm-up result");

        // R2: release at every timer phase
        mask = 8'h00;
        for (int off = 0; off < 8; off++) begin
            run_conv(8'h5A, 2 + off, lat, dur);
            check(lat >= 1 && lat <= 8, "R2 start latency", lat, 8);
            if (lat >= 1 && lat <= 8) mask[lat-1] = 1'b1;
            read_result(8'h5A, "R4 result after phase sweep");
        end
        check(mask == 8'hFF, "R2 all latencies seen", int'(mask), 8'hFF);

        // R7 and R8: mid-conversion read, then abort
        target = 8'h33;
        wr_reg = 1'b0;
        repeat (2) @(negedge clk);
        wr_reg = 1'b1;
        repeat (30) @(negedge clk);
        check(intr_n == 1'b1, "R5 high while converting", int'(intr_n), 1);
        rd_n = 1'b0;
        #1;
        check(data_out == 8'h5A, "R7 previous result held", int'(data_out), 8'h5A);
        @(negedge clk);
        rd_n = 1'b1;
        repeat (9) @(negedge clk);
        check(trial_code != 8'h00, "R8 conversion in progress", int'(trial_code), 1);
        wr_reg = 1'b0;
        @(negedge clk);
        check(trial_code == 8'h00, "R8 abort clears trial", int'(trial_code), 0);
        repeat (5) @(negedge clk);
        check(intr_n == 1'b1 && trial_code == 8'h00, "R8 stays aborted", int'(trial_code), 0);
        target = 8'hC7;
        wr_reg = 1'b1;
        wait_intr(cnt);
        check(cnt >= 66 && cnt <= 73, "R8 restart time", cnt, 70);
        read_result(8'hC7, "R8 result after abort");

        // R4: comparator never high
        never_above = 1'b1;
        run_conv(8'hFF, 3, lat, dur);
        read_result(8'h00, "R4 non-positive input");
        never_above = 1'b0;

        // R9 and R4: free-running sweep over every code
        free_run = 1'b1;
        target   = 8'h00;
        wr_reg   = 1'b0;
        @(negedge clk);
        wr_reg = 1'b1;
        for (int t = 0; t < 256; t++) begin
            wait_intr(cnt);
            if (t > 0) check(cnt + 1 >= 67 && cnt + 1 <= 74, "R9 back-to-back period", cnt + 1, 70);
            rd_n = 1'b0;
            #1;
            check(data_out == 8'(t), "R4 free-run result", int'(data_out), t);
            target = 8'(t + 1);
            @(negedge clk);
            rd_n = 1'b1;
        end
        free_run = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule